// File: doc/BRIEF.md
# Programmable I2C SCL Clock Generator

This block produces the serial clock of an I2C master from the system clock. A 5-bit rate code sets the clock period, and a mode bit picks one of two scalings. In standard timing one SCL period lasts eight times the rate code in system clocks. In fast timing it lasts four times the rate code. In fast timing, rate code 5 is a special short period of ten system clocks with a shortened high time. Rate codes too small for the selected mode are refused.

A byte-start strobe launches a burst of data clocks. The number of clocks comes from a 3-bit count. After the data clocks, an optional ninth acknowledge clock can follow, and during it the block presents a selected SDA level. A per-bit strobe marks the start of each data clock. A done pulse closes the burst.

The controller is a four-state machine:
- `ST_IDLE`: SCL is released high.
- `ST_HIGH`: the high phase of a pulse.
- `ST_LOW`: the low phase of a pulse.
- `ST_DONE`: a single completion cycle.

Its transitions are:
- `ST_IDLE`→`ST_HIGH` on an accepted start.
- `ST_HIGH`→`ST_LOW` when the high time expires.
- `ST_LOW`→`ST_HIGH` when another data clock or the acknowledge clock remains.
- `ST_LOW`→`ST_DONE` after the final pulse.
- `ST_DONE`→`ST_IDLE` unconditionally.
- Any state→`ST_IDLE` when enable is low.

Top module: `i2c_scl_gen`

## Requirements
- R1: In standard mode (`fast_mode`=0) with a legal rate code N, each SCL pulse lasts 8·N system clocks: SCL is high for the first 4·N and low for the remaining 4·N. The first high cycle appears in the cycle after the clock edge that accepts `start`.
- R2: In fast mode (`fast_mode`=1) with a legal rate code N other than 5, each pulse lasts 4·N system clocks: 2·N high, then 2·N low.
- R3: In fast mode with rate code 5, each pulse is 4 system clocks high followed by 6 low.
- R4: Rate codes 0–4 in standard mode and 0–2 in fast mode are illegal. A `start` given with an illegal code is ignored: SCL stays high, and neither `bit_stb` nor `done` is raised.
- R5: A burst has `bit_cnt` data clocks, where the value 0 means 8. `bit_stb` is high for exactly one cycle, the first high cycle of each data clock.
- R6: When `ack_clk_en`=1 at start, one further pulse follows the data clocks, with the same timing and no `bit_stb`. When `ack_clk_en`=0, no further pulse follows.
- R7: During the high and low phases of the acknowledge pulse, `sda_ack` equals the `ack_nak` value captured at start (0 drives low to acknowledge, 1 releases). In every other cycle `sda_ack` is 1.
- R8: `done` is high for exactly one cycle, the cycle after the final low phase. After it, the block is idle with SCL high.
- R9: While `en` is low, the clock edge returns the block to idle. From the next cycle on, SCL is high and there are no strobes. Raising `en` again does not resume the burst.
- R10: Rate, mode, count and acknowledge settings are captured when `start` is accepted. Changing them, or pulsing `start`, during a burst has no effect on that burst.
- R11: After reset, `scl`=1, `sda_ack`=1, `bit_stb`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low forces idle |
| rate | input | 5 | SCL rate code |
| fast_mode | input | 1 | 0 selects standard scaling, 1 selects fast scaling |
| ack_clk_en | input | 1 | Add an acknowledge clock after the data clocks |
| ack_nak | input | 1 | SDA level during the acknowledge clock |
| start | input | 1 | Begin a burst (accepted only when idle) |
| bit_cnt | input | 3 | Data clocks per burst, 0 meaning 8 |
| scl | output | 1 | Generated serial clock level |
| bit_stb | output | 1 | One-cycle marker at the start of each data clock |
| sda_ack | output | 1 | SDA value for the acknowledge slot, 1 otherwise |
| done | output | 1 | One-cycle burst completion pulse |

## Verification
Bursts are run in the following configurations:
- Standard timing at the smallest legal code, with a two-clock burst. This pins the 8·N period and the half-and-half split.
- Standard timing with a count of 0. This shows the count is read as eight, and it adds an acknowledge clock driven low.
- Fast timing at its smallest legal code and at code 31, with the acknowledge released high. These separate the 4·N scaling from the standard scaling.
- Fast timing at code 5. This distinguishes the 4/6 split from a plain 50% duty.

Illegal codes in each mode, a burst whose settings and start line change midway, and an enable drop in a low phase check that the block refuses, latches and abandons work as required.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_DONE = 2'd3
    } scl_state_e;
endpackage

// File: rtl/scl_timing.sv
// Derives phase lengths and legality from the rate code and mode.
module scl_timing #(
    parameter int RATE_W       = 5,
    parameter int PH_W         = RATE_W + 3,
    parameter int MIN_STD      = 5,
    parameter int MIN_FAST     = 3,
    parameter int SPECIAL_CODE = 5,
    parameter int SPECIAL_HI   = 4,
    parameter int SPECIAL_LO   = 6
) (
    input  logic [RATE_W-1:0] rate,
    input  logic              fast_mode,
    output logic              legal,
    output logic [PH_W-1:0]   hi_len,
    output logic [PH_W-1:0]   lo_len
);
    logic [PH_W-1:0] period;

    always_comb begin
        if (fast_mode) begin
            period = PH_W'({rate, 2'b00});
            legal  = (int'(rate) >= MIN_FAST);
        end else begin
            period = PH_W'({rate, 3'b000});
            legal  = (int'(rate) >= MIN_STD);
        end
        if (fast_mode && (int'(rate) == SPECIAL_CODE)) begin
            hi_len = PH_W'(SPECIAL_HI);
            lo_len = PH_W'(SPECIAL_LO);
        end else begin
            hi_len = period >> 1;
            lo_len = period - (period >> 1);
        end
    end
endmodule

// File: rtl/scl_phase_ctr.sv
// Counts system clocks inside one SCL phase.
module scl_phase_ctr #(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [PH_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
    import i2c_scl_pkg::*;
#(
    parameter int RATE_W = 5,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    input  logic              fast_mode,
    input  logic              ack_clk_en,
    input  logic              ack_nak,
    input  logic              start,
    input  logic [CNT_W-1:0]  bit_cnt,
    output logic              scl,
    output logic              bit_stb,
    output logic              sda_ack,
    output logic              done
);
    localparam int PH_W   = RATE_W + 3;
    localparam int BITS_W = CNT_W + 1;

    scl_state_e        state;
    logic [PH_W-1:0]   hi_q, lo_q, cnt, hi_calc, lo_calc;
    logic [BITS_W-1:0] bits_q;
    logic              legal, ack_en_q, nak_q, ack_ph;
    logic              hi_end, lo_end, cnt_clr;

    scl_timing #(.RATE_W(RATE_W), .PH_W(PH_W)) u_timing (
        .rate(rate), .fast_mode(fast_mode), .legal(legal),
        .hi_len(hi_calc), .lo_len(lo_calc)
    );

    assign hi_end  = (state == ST_HIGH) && (cnt == hi_q - 1'b1);
    assign lo_end  = (state == ST_LOW)  && (cnt == lo_q - 1'b1);
    assign cnt_clr = !en || hi_end || lo_end ||
                     (state == ST_IDLE) || (state == ST_DONE);

    scl_phase_ctr #(.PH_W(PH_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .cnt(cnt)
    );

    // State register and captured burst settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hi_q     <= '0;
            lo_q     <= '0;
            bits_q   <= '0;
            ack_en_q <= 1'b0;
            nak_q    <= 1'b1;
            ack_ph   <= 1'b0;
        end else if (!en) begin
            state  <= ST_IDLE;
            ack_ph <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start && legal) begin
                        state    <= ST_HIGH;
                        hi_q     <= hi_calc;
                        lo_q     <= lo_calc;
                        bits_q   <= (bit_cnt == '0) ? BITS_W'(1 << CNT_W)
                                                    : BITS_W'(bit_cnt);
                        ack_en_q <= ack_clk_en;
                        nak_q    <= ack_nak;
                        ack_ph   <= 1'b0;
                    end
                end
                ST_HIGH: begin
                    if (hi_end) state <= ST_LOW;
                end
                ST_LOW: begin
                    if (lo_end) begin
                        if (ack_ph) begin
                            state <= ST_DONE;
                        end else if (bits_q == BITS_W'(1)) begin
                            if (ack_en_q) begin
                                ack_ph <= 1'b1;
                                state  <= ST_HIGH;
                            end else begin
                                state  <= ST_DONE;
                            end
                        end else begin
                            bits_q <= bits_q - 1'b1;
                            state  <= ST_HIGH;
                        end
                    end
                end
                ST_DONE: begin
                    state  <= ST_IDLE;
                    ack_ph <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        scl     = 1'b1;
        bit_stb = 1'b0;
        sda_ack = 1'b1;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_HIGH: begin
                bit_stb = (cnt == '0) && !ack_ph;
                if (ack_ph) sda_ack = nak_q;
            end
            ST_LOW: begin
                scl = 1'b0;
                if (ack_ph) sda_ack = nak_q;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk #(
    parameter int MAX_LO = 124
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl,
    input logic bit_stb,
    input logic sda_ack,
    input logic done
);
    int unsigned lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   lo_run <= 0;
        else if (!scl) lo_run <= lo_run + 1;
        else           lo_run <= 0;
    end

    assert_stb_in_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> (scl && sda_ack));

    assert_done_after_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!$past(scl) && scl && sda_ack && !bit_stb));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl && !bit_stb && !done && sda_ack));

    assert_low_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !scl |-> (lo_run < MAX_LO));
endmodule

bind i2c_scl_gen i2c_scl_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .scl(scl),
    .bit_stb(bit_stb), .sda_ack(sda_ack), .done(done)
);

// File: tb/i2c_scl_gen_tb.sv
module i2c_scl_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [4:0] rate = '0;
    logic       fast_mode = 1'b0;
    logic       ack_clk_en = 1'b0;
    logic       ack_nak = 1'b1;
    logic       start = 1'b0;
    logic [2:0] bit_cnt = '0;
    logic       scl, bit_stb, sda_ack, done;

    always #2 clk = ~clk;

    i2c_scl_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .rate(rate), .fast_mode(fast_mode),
        .ack_clk_en(ack_clk_en), .ack_nak(ack_nak), .start(start),
        .bit_cnt(bit_cnt), .scl(scl), .bit_stb(bit_stb),
        .sda_ack(sda_ack), .done(done)
    );

    typedef struct {
        logic [3:0] v;
        string      tag;
    } item_t;

    item_t q[$];
    logic  go = 1'b0;
    int    checks = 0;
    int    fails = 0;
    bit    finished = 0;

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {scl,stb,sda,done} actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: compares each cycle against the queue
    always @(negedge clk) begin
        if (go && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check({scl, bit_stb, sda_ack, done}, it.v, it.tag);
            if (q.size() == 0) go = 1'b0;
        end
    end

    task automatic push_byte(input int r, input bit f, input int n, input bit ac,
                             input bit nk, input string tag);
        int hi, lo, nb;
        if (f && r == 5) begin hi = 4; lo = 6; end
        else if (f) begin hi = 2*r; lo = 2*r; end
        else begin hi = 4*r; lo = 4*r; end
        nb = (n == 0) ? 8 : n;
        for (int b = 0; b < nb + (ac ? 1 : 0); b++) begin
            bit is_ack;
            is_ack = (b == nb);
            for (int c = 0; c < hi; c++)
                q.push_back('{{1'b1, (c == 0 && !is_ack), (is_ack ? nk : 1'b1), 1'b0}, tag});
            for (int c = 0; c < lo; c++)
                q.push_back('{{1'b0, 1'b0, (is_ack ? nk : 1'b1), 1'b0}, tag});
        end
        q.push_back('{4'b1011, {tag, "/R8"}});
    endtask

    task automatic run_byte(input int r, input bit f, input int n, input bit ac,
                            input bit nk, input bit disturb, input string tag);
        @(negedge clk);
        rate = 5'(r); fast_mode = f; bit_cnt = 3'(n);
        ack_clk_en = ac; ack_nak = nk; start = 1'b1;
        push_byte(r, f, n, ac, nk, tag);
        go <= 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R10: change everything and re-pulse start mid-burst
            repeat (3) @(negedge clk);
            rate = 5'd31; fast_mode = ~f; bit_cnt = 3'd1;
            ack_clk_en = ~ac; ack_nak = ~nk; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        check({scl, bit_stb, sda_ack, done}, 4'b1010, {tag, "/R8 idle"});
    endtask

    task automatic try_illegal(input int r, input bit f, input string tag);
        @(negedge clk);
        rate = 5'(r); fast_mode = f; bit_cnt = 3'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 30; i++) begin
            check({scl, bit_stb, sda_ack, done}, 4'b1010, tag);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({scl, bit_stb, sda_ack, done}, 4'b1010, "R11 reset");
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1;
        check({scl, bit_stb, sda_ack, done}, 4'b1010, "R11 after reset");

        run_byte(5, 0, 2, 0, 1, 0, "R1 std rate5");
        run_byte(6, 0, 0, 1, 0, 0, "R5 R6 R7 std count0 ack");
        run_byte(3, 1, 3, 1, 1, 0, "R2 R7 fast rate3 nak");
        run_byte(5, 1, 1, 0, 1, 0, "R3 fast rate5");
        run_byte(31, 1, 1, 0, 1, 0, "R2 fast rate31");
        run_byte(9, 0, 2, 1, 0, 1, "R10 latched settings");
        try_illegal(4, 0, "R4 std rate4");
        try_illegal(0, 0, "R4 std rate0");
        try_illegal(2, 1, "R4 fast rate2");

        // R9: drop enable during a low phase
        @(negedge clk);
        rate = 5'd5; fast_mode = 1'b0; bit_cnt = 3'd1; ack_clk_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (23) @(negedge clk);
        check({scl, bit_stb, sda_ack, done}, 4'b0010, "R9 in low phase");
        en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            check({scl, bit_stb, sda_ack, done}, 4'b1010, "R9 disabled");
            @(negedge clk);
        end
        en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            check({scl, bit_stb, sda_ack, done}, 4'b1010, "R9 no resume");
            @(negedge clk);
        end
        run_byte(5, 0, 1, 0, 1, 0, "R9 restart");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule